// File: doc/BRIEF.md
# SM4 Key-Schedule Byte Step Unit

This unit performs one byte-wide step of the SM4 key-expansion nonlinear transform, as a processor crypto instruction would. Each request carries a 32-bit accumulator word, a 32-bit key word and a 2-bit lane select. The unit takes the byte of the key word named by the lane select and substitutes it through the SM4 S-box. It zero-extends the substituted byte to 32 bits and mixes it with the key-schedule linear layer, which uses rotations by 13 and 23. It then rotates the mixed word left into the selected byte lane and XORs it into the accumulator.

Four requests with lane selects 0, 1, 2 and 3, each using the previous result as the accumulator and the same key word, leave the starting accumulator XORed with the full key-schedule transform of that key word. The S-box is computed from its algebraic form: a GF(2^8) inverse between two affine maps. It holds no stored table. Every request takes exactly one clock cycle, whatever the operand values.

Top module: `keysched_byte_step`

## Requirements
- R1: The byte sent to the S-box is bits [8*lane_sel+7 : 8*lane_sel] of key_in. The other three bytes of key_in have no effect on the result.
- R2: The substitution is the SM4 S-box. Sample values: 0x00→0xD6, 0x01→0x90, 0x02→0xE9, 0x0F→0x05, 0x10→0x2B, 0xFF→0x48.
- R3: The substituted byte b is zero-extended to 32 bits, and the mixed word is c = b ^ rotl(b,13) ^ rotl(b,23), using 32-bit rotate-left.
- R4: The result is acc_in ^ rotl(c, 8*lane_sel).
- R5: For every request, res_valid is high and res_word holds its result exactly one cycle after req_valid is high, for every lane_sel and every data value. Back-to-back requests are accepted on every cycle.
- R6: In a cycle after req_valid was low, res_valid is low and res_word keeps its previous value, whatever acc_in and key_in do.
- R7: A synchronous active-low reset clears res_valid and res_word to zero.
- R8: Four chained requests with lane_sel 0, 1, 2, 3, the same key_in, and each result fed back as acc_in, give acc0 ^ L(S4(key_in)). Here S4 substitutes all four bytes and L(w) = w ^ rotl(w,13) ^ rotl(w,23).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe; operands are captured on this cycle |
| acc_in | input | 32 | Accumulator word to XOR into |
| key_in | input | 32 | Key word supplying the substituted byte |
| lane_sel | input | 2 | Byte lane for both byte selection and output rotation |
| res_valid | output | 1 | Result strobe, one cycle after req_valid |
| res_word | output | 32 | Result word, held between requests |

## Verification
The assertions assume that req_valid, acc_in, key_in and lane_sel are stable, known values at each rising edge. They also assume that reset is applied before the first request, since the result-form check looks one cycle back to the accepted operands. The stimulus changes every input only on the falling edge, holds reset low for several cycles before any request, and drives req_valid low between scenarios. This keeps the one-cycle hold and latency properties in their stated conditions.

// File: rtl/ksstep_pkg.sv
// Package ksstep_pkg
// Shared widths, field constants and GF(2^8) helpers for the SM4
// key-schedule byte step. Assumes 8-bit bytes and a word that is a whole
// number of bytes.
package ksstep_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int SEL_W  = $clog2(LANES);
    localparam int ROT_A  = 13;
    localparam int ROT_B  = 23;

    // Field polynomial x^8+x^7+x^6+x^5+x^4+x^2+1 without its top term
    localparam logic [7:0] POLY_LOW  = 8'hF5;
    // First row of the circulant affine matrix, and the affine constant
    localparam logic [7:0] AFF_ROW   = 8'hE5;
    localparam logic [7:0] AFF_CONST = 8'hD3;

    // Multiply two field elements modulo the SM4 field polynomial
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[7] ? ((sh << 1) ^ POLY_LOW) : (sh << 1);
        end
        return acc;
    endfunction

    // Field inverse as a^254; zero maps to zero
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] r;
        sq = a;
        r  = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    // Rotate a byte right by n
    function automatic logic [7:0] ror8(input logic [7:0] v, input int n);
        logic [15:0] dbl;
        dbl = {v, v} >> n;
        return dbl[7:0];
    endfunction

    // Affine map: sum of circulant rows picked by input bits (MSB first), plus constant
    function automatic logic [7:0] affine(input logic [7:0] v);
        logic [7:0] y;
        y = 8'h00;
        for (int j = 0; j < 8; j++) begin
            if (v[7-j]) y = y ^ ror8(AFF_ROW, j);
        end
        return y ^ AFF_CONST;
    endfunction
endpackage

// File: rtl/ksstep_sbox.sv
// Module ksstep_sbox
// Combinational SM4 S-box computed as affine(inverse(affine(x))) in GF(2^8).
// It holds no table, so every input passes through the same logic depth.
module ksstep_sbox
    import ksstep_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [7:0] pre_map;
    logic [7:0] inv_val;

    // Input affine, field inverse, output affine
    always_comb begin
        pre_map = affine(din);
        inv_val = gf_inv(pre_map);
        dout    = affine(inv_val);
    end
endmodule

// File: rtl/ksstep_mix.sv
// Module ksstep_mix
// Zero-extends a substituted byte and applies the key-schedule linear
// layer b ^ rotl(b,RA) ^ rotl(b,RB). Assumes 0 < RA, RB < W.
module ksstep_mix #(
    parameter int W  = 32,
    parameter int BW = 8,
    parameter int RA = 13,
    parameter int RB = 23
) (
    input  logic [BW-1:0] b_in,
    output logic [W-1:0]  c_out
);
    logic [W-1:0] b_ext;
    logic [W-1:0] rot_a;
    logic [W-1:0] rot_b;

    // Zero extension and fixed rotations (wiring only)
    always_comb begin
        b_ext = {{(W-BW){1'b0}}, b_in};
        rot_a = (b_ext << RA) | (b_ext >> (W - RA));
        rot_b = (b_ext << RB) | (b_ext >> (W - RB));
        c_out = b_ext ^ rot_a ^ rot_b;
    end
endmodule

// File: rtl/ksstep_lane_rot.sv
// Module ksstep_lane_rot
// Rotates a word left by whole bytes (sel * BW). Every candidate is built
// in parallel and a flat mux picks one, so the delay does not depend on sel.
module ksstep_lane_rot #(
    parameter int W     = 32,
    parameter int BW    = 8,
    parameter int LN    = W / BW,
    parameter int SW    = $clog2(LN)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] sel,
    output logic [W-1:0]  dout
);
    logic [W-1:0] cand [LN];

    // One rotated copy per lane position
    for (genvar g = 0; g < LN; g++) begin : g_lane
        if (g == 0) begin : g_zero
            assign cand[g] = din;
        end else begin : g_rot
            assign cand[g] = {din[W-1-g*BW:0], din[W-1:W-g*BW]};
        end
    end

    // Lane mux
    always_comb begin
        dout = cand[sel];
    end
endmodule

// File: rtl/keysched_byte_step.sv
// Module keysched_byte_step
// One byte step of the SM4 key-schedule transform:
//   res = acc ^ rotl(L(zext(S(key.byte[sel]))), 8*sel)
// The result is registered; it appears exactly one cycle after req_valid
// and is held until the next request. Synchronous active-low reset.
module keysched_byte_step
    import ksstep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] acc_in,
    input  logic [WORD_W-1:0] key_in,
    input  logic [SEL_W-1:0]  lane_sel,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_word
);
    logic [BYTE_W-1:0] key_bytes [LANES];
    logic [BYTE_W-1:0] picked;
    logic [BYTE_W-1:0] subst;
    logic [WORD_W-1:0] mixed;
    logic [WORD_W-1:0] placed;

    // Split the key word into byte lanes
    for (genvar g = 0; g < LANES; g++) begin : g_bytes
        assign key_bytes[g] = key_in[g*BYTE_W +: BYTE_W];
    end

    // Byte selection
    always_comb begin
        picked = key_bytes[lane_sel];
    end

    ksstep_sbox u_sbox (
        .din  (picked),
        .dout (subst)
    );

    ksstep_mix #(.W(WORD_W), .BW(BYTE_W), .RA(ROT_A), .RB(ROT_B)) u_mix (
        .b_in  (subst),
        .c_out (mixed)
    );

    ksstep_lane_rot #(.W(WORD_W), .BW(BYTE_W), .LN(LANES), .SW(SEL_W)) u_rot (
        .din  (mixed),
        .sel  (lane_sel),
        .dout (placed)
    );

    // Output register: capture on request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_word  <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) res_word <= acc_in ^ placed;
        end
    end

    // ---------------- assertions ----------------
    logic [WORD_W-1:0] chk_delta;
    logic [2*WORD_W-1:0] chk_dbl;
    logic [WORD_W-1:0] chk_back;
    logic [WORD_W-1:0] prev_acc;
    logic [SEL_W-1:0]  prev_sel;

    // Operands of the previous cycle, kept for the result-form check
    always_ff @(posedge clk) begin
        prev_acc <= acc_in;
        prev_sel <= lane_sel;
    end

    // Undo the lane rotation of the previous request to expose the mixed word
    always_comb begin
        chk_delta = res_word ^ prev_acc;
        chk_dbl   = {chk_delta, chk_delta} >> (32'(prev_sel) * BYTE_W);
        chk_back  = chk_dbl[WORD_W-1:0];
    end

    assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    assert_hold_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(res_word));

    // R3/R4: after un-rotation, the three copies of the byte agree and gaps are zero
    assert_mix_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(rst_n)) |->
            ((chk_back[BYTE_W-1:0] == chk_back[ROT_A +: BYTE_W]) &&
             (chk_back[BYTE_W-1:0] == chk_back[ROT_B +: BYTE_W]) &&
             (chk_back[ROT_A-1:BYTE_W] == '0)));
endmodule

// File: tb/test_keysched_byte_step.sv
// Directed bench for keysched_byte_step; one task per scenario.
module test_keysched_byte_step;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] acc_in = '0;
    logic [31:0] key_in = '0;
    logic [1:0]  lane_sel = '0;
    logic        res_valid;
    logic [31:0] res_word;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    keysched_byte_step i_keysched_byte_step (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .acc_in(acc_in), .key_in(key_in), .lane_sel(lane_sel),
        .res_valid(res_valid), .res_word(res_word)
    );

    // Known S-box points (R2)
    function automatic logic [7:0] sbox_ref(input logic [7:0] v);
        case (v)
            8'h00: return 8'hD6;
            8'h01: return 8'h90;
            8'h02: return 8'hE9;
            8'h0F: return 8'h05;
            8'h10: return 8'h2B;
            8'hFF: return 8'h48;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] rotl(input logic [31:0] v, input int n);
        logic [63:0] d;
        d = {v, v} << n;
        return d[63:32];
    endfunction

    function automatic logic [31:0] lin(input logic [31:0] w);
        return w ^ rotl(w, 13) ^ rotl(w, 23);
    endfunction

    function automatic logic [31:0] step_ref(input logic [31:0] x, input logic [31:0] k,
                                             input int bs);
        logic [7:0] b;
        b = k[8*bs +: 8];
        return x ^ rotl(lin({24'h0, sbox_ref(b)}), 8*bs);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // One request; returns at the falling edge after the capturing edge
    task automatic send(input logic [31:0] x, input logic [31:0] k, input int bs);
        @(negedge clk);
        acc_in = x; key_in = k; lane_sel = 2'(bs); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R7 res_valid", {31'h0, res_valid}, 32'h0);
        chk("R7 res_word", res_word, 32'h0);
    endtask

    task automatic t_byte_select;
        logic [31:0] first;
        for (int bs = 0; bs < 4; bs++) begin
            send(32'h0, 32'hFF100201, bs);
            chk("R1/R4 lane", res_word, step_ref(32'h0, 32'hFF100201, bs));
        end
        send(32'h0, 32'hFF100201, 2);
        first = res_word;
        send(32'h0, 32'h0F10FF00, 2);
        chk("R1 other bytes ignored", res_word, first);
    endtask

    task automatic t_sbox_points;
        logic [7:0] pts [6] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'hFF};
        for (int i = 0; i < 6; i++) begin
            send(32'h0, {24'h0, pts[i]}, 0);
            // R3: with acc 0 and lane 0 the low byte equals S(b)
            chk("R2 sbox", {24'h0, res_word[7:0]}, {24'h0, sbox_ref(pts[i])});
            chk("R3 mix", res_word, lin({24'h0, sbox_ref(pts[i])}));
        end
    endtask

    task automatic t_xor_acc;
        send(32'hDEADBEEF, 32'h10FF0F02, 1);
        chk("R4 xor acc lane1", res_word, step_ref(32'hDEADBEEF, 32'h10FF0F02, 1));
        send(32'h13579BDF, 32'h10FF0F02, 3);
        chk("R4 xor acc lane3", res_word, step_ref(32'h13579BDF, 32'h10FF0F02, 3));
    endtask

    task automatic t_hold;
        logic [31:0] kept;
        send(32'h01234567, 32'h00000010, 0);
        kept = res_word;
        chk("R5 valid after request", {31'h0, res_valid}, 32'h1);
        for (int i = 0; i < 3; i++) begin
            acc_in = 32'hFFFF0000 ^ i; key_in = 32'h0F0F0F0F; lane_sel = 2'(i);
            @(negedge clk);
            chk("R6 word held", res_word, kept);
            chk("R6 valid low", {31'h0, res_valid}, 32'h0);
        end
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        acc_in = 32'hAAAA5555; key_in = 32'h02010FFF; lane_sel = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        chk("R5 b2b first", res_word, step_ref(32'hAAAA5555, 32'h02010FFF, 0));
        acc_in = 32'h00000000; lane_sel = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 b2b second", res_word, step_ref(32'h0, 32'h02010FFF, 3));
        chk("R5 b2b valid", {31'h0, res_valid}, 32'h1);
    endtask

    task automatic t_chain;
        logic [31:0] acc;
        logic [31:0] k;
        logic [31:0] x0;
        logic [31:0] sw;
        k = 32'hFF100201;
        x0 = 32'hA5A55A5A;
        acc = x0;
        for (int bs = 0; bs < 4; bs++) begin
            send(acc, k, bs);
            chk("R8 chain step", res_word, step_ref(acc, k, bs));
            acc = res_word;
        end
        sw = {sbox_ref(k[31:24]), sbox_ref(k[23:16]), sbox_ref(k[15:8]), sbox_ref(k[7:0])};
        chk("R8 chain total", acc, x0 ^ lin(sw));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_byte_select();
        t_sbox_points();
        t_xor_acc();
        t_hold();
        t_back_to_back();
        t_chain();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule